// File: doc/BRIEF.md
# Pipelined SRAM Command and Bus Control

This block is the control path of a synchronous, pipelined static memory whose shared data bus never needs an idle turnaround cycle between reads and writes. Every enabled rising clock edge samples three select inputs, a write strobe, active-low per-lane write strobes and an address. The command then moves through a three-stage register pipeline, so a new read or write can be issued on every cycle.

Read data is loaded into an output register and offered on the bus in the same pipeline slot that a write uses for its data, so reads and writes can interleave freely. A small behavioural array stores each word as byte lanes, each lane carrying its own parity bit. The bus drive enable comes from the pipeline state and an asynchronous output-enable input. A high clock enable freezes the whole block for that edge without deselecting it.

Top module: `sram_pipe_ctl`

## Requirements
- R1: A command is accepted only on an enabled edge with sel_a_n low, sel_b high and sel_c_n low; wr_n low makes it a write, wr_n high a read. Any other select combination is a deselect cycle that touches neither the array nor the bus.
- R2: A read captured at enabled edge E loads its word into rdata/rpar at enabled edge E+2. It is driven (bus_drive high when out_en_n is low) for the cycle that follows.
- R3: For a write captured at edge E, the data is taken from wdata/wpar at enabled edge E+3. Lane b (wdata[8b+7:8b] together with wpar[b]) is stored only if lane_wr_n[b] was low at E.
- R4: While out_en_n is high, bus_drive is low, following out_en_n combinationally.
- R5: During the data cycle of a write, bus_drive is low whatever out_en_n is.
- R6: During the data cycle of a deselect, including the first cycles after leaving a deselected state, bus_drive is low whatever out_en_n is.
- R7: An edge with clk_en_n high is ignored. The pipeline, the array and rdata/rpar all hold, and the drive state of the current data cycle is kept, so a stall never acts as a deselect.
- R8: A write with every lane_wr_n bit high is an aborted write. It leaves the array unchanged and the bus undriven.
- R9: Reads and writes may alternate on consecutive cycles with no idle cycle. A read issued right after a write to the same address returns the newly written lanes and the old content of the unwritten lanes.
- R10: A synchronous active-low reset empties the pipeline, clears rdata/rpar to zero and leaves bus_drive low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the edge |
| sel_a_n | input | 1 | Select, active low |
| sel_b | input | 1 | Select, active high |
| sel_c_n | input | 1 | Select, active low |
| wr_n | input | 1 | Write strobe, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | 8*LANES | Write data from the bus |
| wpar | input | LANES | Write parity bits from the bus |
| rdata | output | 8*LANES | Registered read data |
| rpar | output | LANES | Registered read parity bits |
| bus_drive | output | 1 | High when the block drives the data and parity lines |

## Verification
The bench first fills the array with back-to-back writes, then reads it back in an unbroken stream, which separates the read latency from the write latency. Alternating write/read pairs to the same address exercise the same-edge forwarding path. Single-lane and aborted writes show that each lane is gated together with its parity bit. Partial select combinations, toggles of out_en_n across read data cycles, stalls placed inside read and write data cycles, and reads issued right after deselect cycles each isolate one of the conditions that force the bus off or hold the pipeline.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // Device responds only to the one select combination
  function automatic logic chip_selected(input logic sel_a_n, input logic sel_b,
                                         input logic sel_c_n);
    return !sel_a_n && sel_b && !sel_c_n;
  endfunction

  function automatic op_e decode_op(input logic sel, input logic wr_n);
    if (!sel)      return OP_NONE;
    else if (wr_n) return OP_RD;
    else           return OP_WR;
  endfunction

  // Same-edge forwarding test for one lane
  function automatic logic lane_forward(input logic lane_we, input logic addr_eq);
    return lane_we && addr_eq;
  endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
module sram_cmd_decode
  import sram_pipe_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  output op_e              cmd_op,
  output logic [LANES-1:0] cmd_be
);

  logic sel;

  always_comb begin
    sel    = chip_selected(sel_a_n, sel_b, sel_c_n);
    cmd_op = decode_op(sel, wr_n);
    cmd_be = (cmd_op == OP_WR) ? ~lane_wr_n : '0;
  end

endmodule

// File: rtl/sram_cmd_pipe.sv
module sram_cmd_pipe
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_be,
  output op_e               st_op   [STAGES],
  output logic [ADDR_W-1:0] st_addr [STAGES],
  output logic [LANES-1:0]  st_be   [STAGES]
);

  localparam int LAST = STAGES - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        st_op[s]   <= OP_NONE;
        st_addr[s] <= '0;
        st_be[s]   <= '0;
      end
    end else if (adv) begin
      st_op[0]   <= in_op;
      st_addr[0] <= in_addr;
      st_be[0]   <= in_be;
      for (int s = 1; s < STAGES; s++) begin
        st_op[s]   <= st_op[s-1];
        st_addr[s] <= st_addr[s-1];
        st_be[s]   <= st_be[s-1];
      end
    end
  end

  AST_PIPE_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(st_op[LAST]) && $stable(st_addr[LAST])); // R7

  AST_PIPE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> st_op[LAST] == $past(st_op[LAST-1])); // R2

endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [LANES-1:0]   wr_be,
  input  logic [8*LANES-1:0] wr_data,
  input  logic [LANES-1:0]   wr_par,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [8*LANES-1:0] rd_data,
  output logic [LANES-1:0]   rd_par
);

  localparam int DEPTH = 1 << ADDR_W;

  logic addr_eq;
  assign addr_eq = (wr_addr == rd_addr);

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [8:0] lane_q [DEPTH];
    logic       lane_we;
    logic       fwd;
    logic [8:0] wr_word;

    assign lane_we = wr_en && wr_be[b];
    assign fwd     = lane_forward(lane_we, addr_eq);
    assign wr_word = {wr_par[b], wr_data[8*b +: 8]};

    always_ff @(posedge clk) begin
      if (lane_we) lane_q[wr_addr] <= wr_word;
    end

    assign {rd_par[b], rd_data[8*b +: 8]} = fwd ? wr_word : lane_q[rd_addr];
  end

endmodule

// File: rtl/sram_bus_drive.sv
module sram_bus_drive
  import sram_pipe_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               load_rd,
  input  logic [8*LANES-1:0] rd_data,
  input  logic [LANES-1:0]   rd_par,
  input  op_e                phase_op,
  input  logic               out_en_n,
  output logic [8*LANES-1:0] dout,
  output logic [LANES-1:0]   dout_par,
  output logic               drive
);

  logic phase_rd;
  logic load_edge;

  assign phase_rd  = (phase_op == OP_RD);
  assign load_edge = adv && load_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout     <= '0;
      dout_par <= '0;
    end else if (load_edge) begin
      dout     <= rd_data;
      dout_par <= rd_par;
    end
  end

  assign drive = phase_rd && !out_en_n;

  AST_STALL_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable({dout_par, dout})); // R7

endmodule

// File: rtl/sram_pipe_ctl.sv
module sram_pipe_ctl
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_en_n,
  input  logic               sel_a_n,
  input  logic               sel_b,
  input  logic               sel_c_n,
  input  logic               wr_n,
  input  logic [LANES-1:0]   lane_wr_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               out_en_n,
  input  logic [8*LANES-1:0] wdata,
  input  logic [LANES-1:0]   wpar,
  output logic [8*LANES-1:0] rdata,
  output logic [LANES-1:0]   rpar,
  output logic               bus_drive
);

  localparam int STAGES = 3;
  localparam int LAST   = STAGES - 1;
  localparam int LOAD   = STAGES - 2;

  // Named internal events
  logic               adv;
  logic               sel_in;
  logic               wr_commit;
  logic               rd_load;
  op_e                dec_op;
  logic [LANES-1:0]   dec_be;
  op_e                st_op   [STAGES];
  logic [ADDR_W-1:0]  st_addr [STAGES];
  logic [LANES-1:0]   st_be   [STAGES];
  logic [8*LANES-1:0] arr_data;
  logic [LANES-1:0]   arr_par;

  assign adv       = !clk_en_n;
  assign sel_in    = chip_selected(sel_a_n, sel_b, sel_c_n);
  assign wr_commit = adv && rst_n && (st_op[LAST] == OP_WR);
  assign rd_load   = (st_op[LOAD] == OP_RD);

  sram_cmd_decode #(.LANES(LANES)) u_decode (
    .sel_a_n   (sel_a_n),
    .sel_b     (sel_b),
    .sel_c_n   (sel_c_n),
    .wr_n      (wr_n),
    .lane_wr_n (lane_wr_n),
    .cmd_op    (dec_op),
    .cmd_be    (dec_be)
  );

  sram_cmd_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .STAGES(STAGES)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (adv),
    .in_op   (dec_op),
    .in_addr (addr),
    .in_be   (dec_be),
    .st_op   (st_op),
    .st_addr (st_addr),
    .st_be   (st_be)
  );

  sram_byte_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_array (
    .clk     (clk),
    .wr_en   (wr_commit),
    .wr_addr (st_addr[LAST]),
    .wr_be   (st_be[LAST]),
    .wr_data (wdata),
    .wr_par  (wpar),
    .rd_addr (st_addr[LOAD]),
    .rd_data (arr_data),
    .rd_par  (arr_par)
  );

  sram_bus_drive #(.LANES(LANES)) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (adv),
    .load_rd  (rd_load),
    .rd_data  (arr_data),
    .rd_par   (arr_par),
    .phase_op (st_op[LAST]),
    .out_en_n (out_en_n),
    .dout     (rdata),
    .dout_par (rpar),
    .drive    (bus_drive)
  );

  AST_DESELECT_ENTERS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !sel_in) |=> st_op[0] == OP_NONE); // R1

  AST_OE_HIGH_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> !bus_drive); // R4

  AST_WRITE_PHASE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_op[LAST] == OP_WR) |-> !bus_drive); // R5

  AST_DESELECT_PHASE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_op[LAST] == OP_NONE) |-> !bus_drive); // R6

endmodule

// File: tb/sram_pipe_ctl_tb.sv
module sram_pipe_ctl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_en_n = 1'b0;
  logic        sel_a_n = 1'b1;
  logic        sel_b = 1'b0;
  logic        sel_c_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [1:0]  lane_wr_n = 2'b11;
  logic [5:0]  addr = '0;
  logic        out_en_n = 1'b0;
  logic [15:0] wdata;
  logic [1:0]  wpar;
  logic [15:0] rdata;
  logic [1:0]  rpar;
  logic        bus_drive;

  logic [15:0] drv_d = 16'h5AA5;
  logic [1:0]  drv_p = 2'b11;
  assign wdata = drv_d;
  assign wpar  = drv_p;

  logic [15:0] cmd_wd = '0;
  logic [1:0]  cmd_wp = '0;
  string       cmd_tag = "R2";

  int n_tests = 0;
  int n_fail  = 0;

  // Reference model state: index 0 = just captured, 2 = data cycle
  int          m_op   [3] = '{0, 0, 0};
  logic [5:0]  m_addr [3] = '{0, 0, 0};
  logic [1:0]  m_be   [3] = '{0, 0, 0};
  logic [15:0] m_wd   [3] = '{0, 0, 0};
  logic [1:0]  m_wp   [3] = '{0, 0, 0};
  string       m_tag  [3] = '{"R10", "R10", "R10"};
  logic [15:0] md [64];
  logic [1:0]  mp [64];
  logic [15:0] m_dout = '0;
  logic [1:0]  m_doutp = '0;
  bit          m_stalled = 1'b0;

  sram_pipe_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr), .out_en_n(out_en_n),
    .wdata(wdata), .wpar(wpar), .rdata(rdata), .rpar(rpar), .bus_drive(bus_drive)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_op[i] = 0; m_addr[i] = '0; m_be[i] = '0; m_tag[i] = "R10";
      end
      m_dout = '0; m_doutp = '0; m_stalled = 1'b0;
    end else if (clk_en_n) begin
      m_stalled = 1'b1;
    end else begin
      m_stalled = 1'b0;
      if (m_op[2] == 2) begin
        for (int b = 0; b < 2; b++) begin
          if (m_be[2][b]) begin
            md[m_addr[2]][8*b +: 8] = m_wd[2][8*b +: 8];
            mp[m_addr[2]][b] = m_wp[2][b];
          end
        end
      end
      if (m_op[1] == 1) begin
        m_dout  = md[m_addr[1]];
        m_doutp = mp[m_addr[1]];
      end
      for (int i = 2; i > 0; i--) begin
        m_op[i] = m_op[i-1]; m_addr[i] = m_addr[i-1]; m_be[i] = m_be[i-1];
        m_wd[i] = m_wd[i-1]; m_wp[i] = m_wp[i-1]; m_tag[i] = m_tag[i-1];
      end
      if (!sel_a_n && sel_b && !sel_c_n) m_op[0] = wr_n ? 1 : 2;
      else m_op[0] = 0;
      m_addr[0] = addr;
      m_be[0]   = (m_op[0] == 2) ? ~lane_wr_n : 2'b00;
      m_wd[0]   = cmd_wd;
      m_wp[0]   = cmd_wp;
      m_tag[0]  = cmd_tag;
    end
    drv_d <= (m_op[2] == 2) ? m_wd[2] : 16'h5AA5;
    drv_p <= (m_op[2] == 2) ? m_wp[2] : 2'b11;
  end

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    string t_oe;
    string t_d;
    logic  exp_oe;
    exp_oe = (m_op[2] == 1) && !out_en_n;
    if (!rst_n)             t_oe = "R10";
    else if (m_op[2] == 1)  t_oe = out_en_n ? "R4" : m_tag[2];
    else if (m_op[2] == 2)  t_oe = (m_be[2] == 2'b00) ? "R8" : "R5";
    else                    t_oe = "R6";
    if (!rst_n)             t_d = "R10";
    else if (m_stalled)     t_d = "R7";
    else if (m_op[2] == 1)  t_d = m_tag[2];
    else                    t_d = "R2";
    check(t_oe, {17'd0, bus_drive}, {17'd0, exp_oe});
    check(t_d, {rpar, rdata}, {m_doutp, m_dout});
  end

  task automatic put(input logic an, input logic b, input logic cn, input logic wn,
                     input logic [1:0] bwn, input logic [5:0] a, input logic [15:0] d,
                     input logic [1:0] p, input logic oe, input string tg);
    @(posedge clk); #5;
    clk_en_n = 1'b0; sel_a_n = an; sel_b = b; sel_c_n = cn; wr_n = wn;
    lane_wr_n = bwn; addr = a; cmd_wd = d; cmd_wp = p; out_en_n = oe; cmd_tag = tg;
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d, input logic [1:0] p,
                    input logic [1:0] bwn, input string tg);
    put(1'b0, 1'b1, 1'b0, 1'b0, bwn, a, d, p, 1'b0, tg);
  endtask

  task automatic rd(input logic [5:0] a, input logic oe, input string tg);
    put(1'b0, 1'b1, 1'b0, 1'b1, 2'b11, a, 16'h0, 2'b00, oe, tg);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 6'd0, 16'h0, 2'b00, 1'b0, "R6");
  endtask

  task automatic stall(input logic oe);
    @(posedge clk); #5;
    clk_en_n = 1'b1; out_en_n = oe;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    // Fill every word with both lanes (R3)
    for (int a = 0; a < 64; a++)
      wr(6'(a), 16'(a * 16'h0101) ^ 16'h3C00, 2'(a), 2'b00, "R3");
    idle(3);
    // Streamed reads (R2)
    for (int a = 0; a < 8; a++) rd(6'(a), 1'b0, "R2");
    // Alternating write/read to the same address, forwarding (R9)
    for (int i = 0; i < 6; i++) begin
      wr(6'(8 + i), 16'hA000 + 16'(i), 2'(i + 1), 2'b00, "R9");
      rd(6'(8 + i), 1'b0, "R9");
    end
    rd(20, 1'b0, "R9");
    wr(20, 16'h7711, 2'b10, 2'b01, "R9");
    rd(20, 1'b0, "R9");
    // Single-lane writes (R3)
    wr(30, 16'hBEEF, 2'b10, 2'b10, "R3");
    wr(31, 16'hCAFE, 2'b01, 2'b01, "R3");
    rd(30, 1'b0, "R3");
    rd(31, 1'b0, "R3");
    // Aborted write (R8)
    wr(32, 16'h1234, 2'b11, 2'b11, "R8");
    rd(32, 1'b0, "R8");
    idle(2);
    rd(32, 1'b0, "R8");
    // Partial select combinations are deselects (R1)
    put(1'b0, 1'b0, 1'b0, 1'b0, 2'b00, 6'd33, 16'hDEAD, 2'b11, 1'b0, "R1");
    put(1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 6'd34, 16'hDEAD, 2'b11, 1'b0, "R1");
    put(1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 6'd35, 16'hDEAD, 2'b11, 1'b0, "R1");
    put(1'b1, 1'b1, 1'b0, 1'b1, 2'b11, 6'd36, 16'h0, 2'b00, 1'b0, "R1");
    idle(2);
    rd(33, 1'b0, "R1");
    rd(34, 1'b0, "R1");
    rd(35, 1'b0, "R1");
    // Output enable across read data cycles (R4)
    rd(40, 1'b0, "R4");
    rd(41, 1'b1, "R4");
    rd(42, 1'b1, "R4");
    rd(43, 1'b0, "R4");
    idle(1);
    put(1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 6'd0, 16'h0, 2'b00, 1'b1, "R4");
    idle(2);
    // Stalls inside read and write data cycles (R7)
    rd(44, 1'b0, "R7");
    rd(45, 1'b0, "R7");
    stall(1'b0);
    stall(1'b0);
    rd(46, 1'b0, "R7");
    wr(47, 16'h4747, 2'b01, 2'b00, "R7");
    stall(1'b0);
    rd(47, 1'b0, "R7");
    stall(1'b1);
    stall(1'b0);
    idle(3);
    // Reads right after deselect (R6)
    idle(2);
    rd(50, 1'b0, "R6");
    rd(51, 1'b0, "R6");
    idle(4);
    // Reset in mid-stream (R10)
    rd(52, 1'b0, "R10");
    rd(53, 1'b0, "R10");
    @(posedge clk); #5 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #5 rst_n = 1'b1;
    idle(3);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog R2: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule